// File: doc/BRIEF.md
# Branch Target and Gateway Privilege Unit

This block decodes the IA-relative branch instruction of a 64-bit RISC core and computes everything the fetch stage needs to redirect. It gets one instruction word with its own offset and works out four things: the word displacement, the target offset, the link register number and link value, and the privilege level that applies at the target. A gateway variant can raise privilege when the fetch page's type allows it. The block flags an illegal-instruction trap, a request to nullify the following instruction, and a request to push the return point onto a return-address stack.

The block has a single register stage by default. Each accepted instruction produces one result, marked by `out_valid`, on the next clock. The low two bits of the target offset carry the privilege for the target. A smaller number means more privilege.

Top module: `bt_unit`

## Requirements
- R1: A word is a branch only when `insn[31:26]` equals 6'h3A. Each `in_valid` cycle produces exactly one `out_valid` cycle one clock later. For a non-branch word, `br_taken`, `link_we`, `trap_ill`, `nullify_nx` and `push_req` are all 0.
- R2: For sub-opcodes 0 and 1 (`insn[15:13]`), the displacement is built from `insn[0]` (w), `insn[20:16]` (w1) and `insn[12:2]` (w2) as the signed 17-bit value {w, w1, w2[0], w2[10:1]}, multiplied by 4. The upper bits of `br_target` equal bits [63:2] of `cur_off` + displacement + 8.
- R3: For sub-opcodes 4 and 5, the displacement is the signed 22-bit value {w, w3, w1, w2[0], w2[10:1]}, multiplied by 4, where w3 is `insn[25:21]`. The target is formed as in R2.
- R4: The link register is GR2 for sub-opcodes 4 and 5, and `insn[25:21]` otherwise. `link_val[63:2]` equals bits [63:2] of `cur_off` + 8.
- R5: A link whose register number is 0 is discarded: `link_we` stays 0 while `br_taken` still asserts.
- R6: For a gateway branch (sub-opcode 1) with `psw_c`=1, `br_target[1:0]` is `page_type[1:0]` when `page_type` > 3 and `page_type[1:0]` < `cur_priv`. Otherwise it is `cur_priv`.
- R7: For a gateway branch with `psw_c`=0, `br_target[1:0]` is 0.
- R8: For a gateway branch, `link_val[1:0]` holds `cur_priv`. For the other variants it holds `cur_off[1:0]`.
- R9: `trap_ill` asserts for a gateway branch with `psw_b`=1 and for any sub-opcode other than 0, 1, 4 or 5. A trapping branch asserts none of `br_taken`, `link_we`, `nullify_nx` or `push_req`.
- R10: `nullify_nx` equals `insn[1]` for a non-trapping branch.
- R11: `push_req` asserts for sub-opcode 4 when `HAS_STACK` is 1, always together with a link write to GR2.
- R12: For non-gateway branches, `br_target[1:0]` equals `cur_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| cur_off | input | OFF_W | Offset of the instruction |
| psw_b | input | 1 | Taken-branch status bit; a gateway under it traps |
| psw_c | input | 1 | Code translation enable bit |
| cur_priv | input | 2 | Current privilege level |
| page_type | input | 3 | Access-rights type of the fetch page |
| out_valid | output | 1 | Result present |
| br_taken | output | 1 | Non-trapping branch; redirect to `br_target` |
| br_target | output | OFF_W | Target offset with new privilege in [1:0] |
| link_we | output | 1 | Write `link_val` to `link_idx` |
| link_idx | output | 5 | Link register number |
| link_val | output | OFF_W | Return point value |
| trap_ill | output | 1 | Illegal-instruction trap |
| nullify_nx | output | 1 | Nullify the following instruction |
| push_req | output | 1 | Push `link_val` onto the return stack |

## Verification
If a decode flag is held wrongly, the error shows on `link_we`, `push_req` or `trap_ill` in the same result cycle, one clock after the instruction. If a field is swapped in the displacement, `br_target` is off by a power of two and the sign goes wrong for far targets. Privilege mistakes appear only in the two low bits of `br_target` or `link_val`. Because of this, every result is compared bit-exact against a model across random page types, privilege levels and status bits.

// File: rtl/bt_pkg.sv
package bt_pkg;
   localparam int INSN_W = 32;
   localparam int PRIV_W = 2;
   localparam int REG_W  = 5;

   typedef enum logic [2:0] {
      SUB_LINK = 3'd0,
      SUB_GATE = 3'd1,
      SUB_PUSH = 3'd4,
      SUB_LONG = 3'd5
   } sub_e;

   typedef struct packed {
      logic [5:0]  opc;
      logic [4:0]  tw3;
      logic [4:0]  w1;
      logic [2:0]  sub;
      logic [10:0] w2;
      logic        n;
      logic        w;
   } br_fields_t;

   function automatic br_fields_t split(input logic [INSN_W-1:0] x);
      br_fields_t f;
      f.opc = x[31:26];
      f.tw3 = x[25:21];
      f.w1  = x[20:16];
      f.sub = x[15:13];
      f.w2  = x[12:2];
      f.n   = x[1];
      f.w   = x[0];
      return f;
   endfunction
endpackage

// File: rtl/bt_disp.sv
module bt_disp #(
   parameter int OFF_W = 64
) (
   input  bt_pkg::br_fields_t f,
   input  logic               long_form,
   output logic [OFF_W-1:0]   disp
);
   localparam int SHORT_W = 17;
   localparam int LONG_W  = 22;
   localparam int SXS     = OFF_W - SHORT_W - 2;
   localparam int SXL     = OFF_W - LONG_W - 2;

   logic [SHORT_W-1:0] d_short;
   logic [LONG_W-1:0]  d_long;
   logic [OFF_W-1:0]   ext_short;
   logic [OFF_W-1:0]   ext_long;

   assign d_short   = {f.w, f.w1, f.w2[0], f.w2[10:1]};
   assign d_long    = {f.w, f.tw3, f.w1, f.w2[0], f.w2[10:1]};
   assign ext_short = {{SXS{f.w}}, d_short, 2'b00};
   assign ext_long  = {{SXL{f.w}}, d_long, 2'b00};
   assign disp      = long_form ? ext_long : ext_short;
endmodule

// File: rtl/bt_priv.sv
module bt_priv (
   input  logic       gate,
   input  logic       psw_c,
   input  logic [1:0] cur_priv,
   input  logic [2:0] page_type,
   output logic [1:0] new_priv
);
   logic promotes;
   assign promotes = page_type[2] && (page_type[1:0] < cur_priv);

   always_comb begin
      if (!gate)
         new_priv = cur_priv;
      else if (!psw_c)
         new_priv = 2'd0;
      else if (promotes)
         new_priv = page_type[1:0];
      else
         new_priv = cur_priv;
   end
endmodule

// File: rtl/bt_ctl.sv
module bt_ctl #(
   parameter logic [5:0] OPCODE    = 6'h3A,
   parameter bit         HAS_STACK = 1'b1
) (
   input  bt_pkg::br_fields_t f,
   input  logic               psw_b,
   output logic               is_br,
   output logic               gate,
   output logic               long_form,
   output logic               trap,
   output logic               taken,
   output logic               lwe,
   output logic [4:0]         lidx,
   output logic               nul,
   output logic               push
);
   import bt_pkg::*;
   logic legal;
   logic want_push;

   always_comb begin
      is_br     = (f.opc == OPCODE);
      gate      = (f.sub == SUB_GATE);
      long_form = (f.sub == SUB_PUSH) || (f.sub == SUB_LONG);
      legal     = (f.sub == SUB_LINK) || gate || long_form;
      trap      = is_br && (!legal || (gate && psw_b));
      taken     = is_br && !trap;
      lidx      = long_form ? 5'd2 : f.tw3;
      lwe       = taken && (lidx != 5'd0);
      nul       = taken && f.n;
   end

   generate
      if (HAS_STACK) begin : g_stack
         assign want_push = (f.sub == SUB_PUSH);
      end else begin : g_nostack
         assign want_push = 1'b0;
      end
   endgenerate

   assign push = taken && want_push;
endmodule

// File: rtl/bt_unit.sv
module bt_unit #(
   parameter int         OFF_W     = 64,
   parameter logic [5:0] OPCODE    = 6'h3A,
   parameter bit         HAS_STACK = 1'b1,
   parameter bit         REG_OUT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      insn,
   input  logic [OFF_W-1:0] cur_off,
   input  logic             psw_b,
   input  logic             psw_c,
   input  logic [1:0]       cur_priv,
   input  logic [2:0]       page_type,
   output logic             out_valid,
   output logic             br_taken,
   output logic [OFF_W-1:0] br_target,
   output logic             link_we,
   output logic [4:0]       link_idx,
   output logic [OFF_W-1:0] link_val,
   output logic             trap_ill,
   output logic             nullify_nx,
   output logic             push_req
);
   import bt_pkg::*;
   localparam logic [OFF_W-1:0] STEP8 = OFF_W'(8);

   initial begin
      assert (OFF_W >= 32 && OFF_W <= 128)
         else $error("bt_unit: OFF_W out of range");
   end

   br_fields_t       f;
   logic             is_br, gate, long_form, trap, taken, lwe, nul, push;
   logic [4:0]       lidx;
   logic [OFF_W-1:0] disp, sum_t, sum_r, tgt_c, lval_c;
   logic [1:0]       np;

   assign f = split(insn);

   bt_ctl #(.OPCODE(OPCODE), .HAS_STACK(HAS_STACK)) u_ctl (
      .f(f), .psw_b(psw_b), .is_br(is_br), .gate(gate),
      .long_form(long_form), .trap(trap), .taken(taken), .lwe(lwe),
      .lidx(lidx), .nul(nul), .push(push)
   );

   bt_disp #(.OFF_W(OFF_W)) u_disp (
      .f(f), .long_form(long_form), .disp(disp)
   );

   bt_priv u_priv (
      .gate(gate), .psw_c(psw_c), .cur_priv(cur_priv),
      .page_type(page_type), .new_priv(np)
   );

   assign sum_t  = cur_off + disp + STEP8;
   assign sum_r  = cur_off + STEP8;
   assign tgt_c  = {sum_t[OFF_W-1:2], np};
   assign lval_c = {sum_r[OFF_W-1:2], gate ? cur_priv : sum_r[1:0]};

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               br_taken   <= 1'b0;
               br_target  <= '0;
               link_we    <= 1'b0;
               link_idx   <= '0;
               link_val   <= '0;
               trap_ill   <= 1'b0;
               nullify_nx <= 1'b0;
               push_req   <= 1'b0;
            end else begin
               out_valid  <= in_valid;
               br_taken   <= in_valid && taken;
               br_target  <= tgt_c;
               link_we    <= in_valid && lwe;
               link_idx   <= lidx;
               link_val   <= lval_c;
               trap_ill   <= in_valid && trap;
               nullify_nx <= in_valid && nul;
               push_req   <= in_valid && push;
            end
         end
      end else begin : g_comb
         assign out_valid  = in_valid;
         assign br_taken   = in_valid && taken;
         assign br_target  = tgt_c;
         assign link_we    = in_valid && lwe;
         assign link_idx   = lidx;
         assign link_val   = lval_c;
         assign trap_ill   = in_valid && trap;
         assign nullify_nx = in_valid && nul;
         assign push_req   = in_valid && push;
      end
   endgenerate
endmodule

// File: rtl/bt_unit_chk.sv
module bt_unit_chk #(
   parameter int         OFF_W   = 64,
   parameter logic [5:0] OPCODE  = 6'h3A,
   parameter bit         REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [31:0]      insn,
   input logic             psw_b,
   input logic             psw_c,
   input logic [1:0]       cur_priv,
   input logic [OFF_W-1:0] br_target,
   input logic             br_taken,
   input logic             link_we,
   input logic [4:0]       link_idx,
   input logic             trap_ill,
   input logic             nullify_nx,
   input logic             push_req,
   input logic             out_valid
);
   a_r5_no_gr0: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_idx != 5'd0);
   a_r9_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ill |-> !br_taken && !link_we && !nullify_nx && !push_req);
   a_r11_push_gr2: assert property (@(posedge clk) disable iff (!rst_n)
      push_req |-> link_we && link_idx == 5'd2);
   a_r1_taken_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken || trap_ill) |-> out_valid);

   generate
      if (REG_OUT) begin : g_seq
         a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
         a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && insn[31:26] == OPCODE && insn[15:13] == 3'd1
                  && !psw_b && !psw_c) |-> br_target[1:0] == 2'd0);
         a_r6_never_lower: assert property (@(posedge clk) disable iff (!rst_n)
            $past(in_valid && insn[31:26] == OPCODE && insn[15:13] == 3'd1
                  && !psw_b && psw_c) |-> br_target[1:0] <= $past(cur_priv));
         a_r10_nullify: assert property (@(posedge clk) disable iff (!rst_n)
            br_taken |-> nullify_nx == $past(insn[1]));
      end
   endgenerate
endmodule

bind bt_unit bt_unit_chk #(.OFF_W(OFF_W), .OPCODE(OPCODE), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
   .psw_b(psw_b), .psw_c(psw_c), .cur_priv(cur_priv),
   .br_target(br_target), .br_taken(br_taken), .link_we(link_we),
   .link_idx(link_idx), .trap_ill(trap_ill), .nullify_nx(nullify_nx),
   .push_req(push_req), .out_valid(out_valid)
);

// File: tb/bt_unit_bench.sv
module bt_unit_bench;
   localparam int W = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   insn = '0;
   logic [W-1:0]  cur_off = '0;
   logic          psw_b = 1'b0, psw_c = 1'b0;
   logic [1:0]    cur_priv = '0;
   logic [2:0]    page_type = '0;
   logic          out_valid, br_taken, link_we, trap_ill, nullify_nx, push_req;
   logic [W-1:0]  br_target, link_val;
   logic [4:0]    link_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bt_unit u_bt_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .cur_off(cur_off), .psw_b(psw_b), .psw_c(psw_c), .cur_priv(cur_priv),
      .page_type(page_type), .out_valid(out_valid), .br_taken(br_taken),
      .br_target(br_target), .link_we(link_we), .link_idx(link_idx),
      .link_val(link_val), .trap_ill(trap_ill), .nullify_nx(nullify_nx),
      .push_req(push_req)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] t,
                                      input logic [4:0] w1, input logic [2:0] sub,
                                      input logic [10:0] w2, input logic n, input logic w);
      return {opc, t, w1, sub, w2, n, w};
   endfunction

   task automatic run(input logic [31:0] i, input logic [W-1:0] off, input logic b,
                      input logic c, input logic [1:0] cp, input logic [2:0] pt);
      logic [2:0]  sub;
      logic        isb, gate, lng, legal, trp, tk, wbit;
      longint      raw, d;
      logic [W-1:0] t, r;
      logic [1:0]  np;
      logic [4:0]  li;
      @(negedge clk);
      insn = i; cur_off = off; psw_b = b; psw_c = c; cur_priv = cp; page_type = pt;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      sub   = i[15:13];
      isb   = (i[31:26] == 6'h3A);
      gate  = (sub == 3'd1);
      lng   = (sub == 3'd4) || (sub == 3'd5);
      legal = (sub == 3'd0) || gate || lng;
      trp   = isb && (!legal || (gate && b));
      tk    = isb && !trp;
      wbit  = i[0];
      if (lng) begin
         raw = longint'({i[0], i[25:21], i[20:16], i[2], i[12:3]});
         d = raw - (wbit ? (longint'(1) << 22) : 0);
      end else begin
         raw = longint'({i[0], i[20:16], i[2], i[12:3]});
         d = raw - (wbit ? (longint'(1) << 17) : 0);
      end
      d = d * 4;
      if (!gate) np = cp;
      else if (!c) np = 2'd0;
      else if (pt > 3'd3 && pt[1:0] < cp) np = pt[1:0];
      else np = cp;
      t  = off + W'(d) + W'(8);
      r  = off + W'(8);
      li = lng ? 5'd2 : i[25:21];
      chk("R1 out_valid", W'(out_valid), W'(1));
      chk("R9 trap", W'(trap_ill), W'(trp));
      chk("R1 taken", W'(br_taken), W'(tk));
      chk("R5 link_we", W'(link_we), W'(tk && li != 5'd0));
      chk("R10 nullify", W'(nullify_nx), W'(tk && i[1]));
      chk("R11 push", W'(push_req), W'(tk && sub == 3'd4));
      if (tk) begin
         chk(lng ? "R3 target" : "R2 target", {br_target[W-1:2], 2'b00}, {t[W-1:2], 2'b00});
         chk(gate ? (c ? "R6 priv" : "R7 priv") : "R12 priv", W'(br_target[1:0]), W'(np));
         chk("R4 link_idx", W'(link_idx), W'(li));
         chk("R4 link_val", {link_val[W-1:2], 2'b00}, {r[W-1:2], 2'b00});
         chk("R8 link priv", W'(link_val[1:0]), W'(gate ? cp : off[1:0]));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", W'(out_valid), W'(0));
      chk("R1 reset flags", W'({br_taken, link_we, trap_ill, nullify_nx, push_req}), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", W'(out_valid), W'(0));
      // directed corners
      run(mk(6'h3A, 5'd7, 5'd0, 3'd0, 11'd0, 1'b0, 1'b0), 64'h1000, 0, 1, 2'd3, 3'd0); // R2 zero disp
      run(mk(6'h3A, 5'd0, 5'h1F, 3'd0, 11'h7FF, 1'b1, 1'b1), 64'h1000, 0, 1, 2'd3, 3'd0); // R5 GR0, negative
      run(mk(6'h3A, 5'h15, 5'h0A, 3'd5, 11'h001, 1'b0, 1'b0), 64'h4000, 0, 1, 2'd1, 3'd0); // R3 long
      run(mk(6'h3A, 5'h1F, 5'h1F, 3'd4, 11'h7FF, 1'b0, 1'b1), 64'h8000, 0, 1, 2'd2, 3'd0); // R11 push, -4
      run(mk(6'h3A, 5'd3, 5'd1, 3'd1, 11'd4, 1'b0, 1'b0), 64'h2003, 0, 1, 2'd3, 3'd5); // R6 promote to 1
      run(mk(6'h3A, 5'd3, 5'd1, 3'd1, 11'd4, 1'b0, 1'b0), 64'h2000, 0, 1, 2'd0, 3'd6); // R6 no lowering
      run(mk(6'h3A, 5'd3, 5'd1, 3'd1, 11'd4, 1'b0, 1'b0), 64'h2000, 0, 1, 2'd3, 3'd3); // R6 type<=3
      run(mk(6'h3A, 5'd3, 5'd1, 3'd1, 11'd4, 1'b1, 1'b0), 64'h2000, 0, 0, 2'd3, 3'd7); // R7
      run(mk(6'h3A, 5'd3, 5'd1, 3'd1, 11'd4, 1'b1, 1'b0), 64'h2000, 1, 1, 2'd3, 3'd7); // R9 gate B=1
      run(mk(6'h3A, 5'd3, 5'd1, 3'd2, 11'd4, 1'b1, 1'b0), 64'h2000, 0, 1, 2'd3, 3'd7); // R9 bad sub
      run(mk(6'h3B, 5'd3, 5'd1, 3'd4, 11'd4, 1'b1, 1'b0), 64'h2000, 0, 1, 2'd3, 3'd7); // R1 not branch
      // random mix
      void'($urandom(32'd4711));
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] i;
         logic [2:0]  s;
         i = $urandom;
         if ($urandom_range(9) < 8) i[31:26] = 6'h3A;
         s = 3'($urandom_range(3));
         if ($urandom_range(9) < 8) i[15:13] = (s == 3'd2) ? 3'd4 : (s == 3'd3) ? 3'd5 : s;
         run(i, {$urandom, $urandom}, 1'($urandom_range(3) == 0), 1'($urandom),
             2'($urandom), 3'($urandom));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule